// File: doc/BRIEF.md
# I2C SCL Rate Generator

This block produces the serial-clock waveform for an I2C master from the module clock. A prescaler divides the module clock by (PSC+1) into an internal tick. A phase counter then holds SCL low for (LOW + d) ticks and high for (HIGH + d) ticks. Here d is a fixed offset that depends only on the prescaler setting. Two single-cycle strobes mark the points the transfer sequencer needs: one in the middle of the low phase, where SDA may change, and one on the rising edge of SCL, where SDA is sampled.

The three 16-bit settings are taken into a held copy only while the module-run control is low, which is the core's soft reset. Once the core runs, the held values stay fixed. SCL toggles only while the core runs and the sequencer's enable is high. Otherwise SCL rests high, and every new run of periods starts with a complete low phase.

Top module: `scl_rate_gen`

## Requirements
- R1: While `rst` is high, `core_run` is low or `gen_en` is low, `scl_drive` is 1 and both strobes are 0, from the first clock edge on which that condition is seen.
- R2: On the first clock edge where `core_run` and `gen_en` are both 1 after an idle state, `scl_drive` goes to 0, so each run begins with a low phase.
- R3: The low phase lasts exactly (PSC+1)·(LOW+d) module clock cycles, where PSC, LOW and HIGH are the held settings read as unsigned numbers.
- R4: The high phase lasts exactly (PSC+1)·(HIGH+d) cycles, and phases then alternate with period (PSC+1)·(LOW+HIGH+2d).
- R5: The offset d is 7 when PSC is 0, 6 when PSC is 1, and 5 when PSC is 2 or more.
- R6: `rise_stb` is high for exactly one cycle per period: the first cycle in which `scl_drive` is 1 after a low phase.
- R7: `mid_low_stb` is high for exactly one cycle per period, while `scl_drive` is 0, at (PSC+1)·floor((LOW+d)/2) cycles after the low phase began.
- R8: The settings are captured only while `core_run` is 0. Changes to them while `core_run` is 1 have no effect on the waveform.
- R9: Dropping `gen_en` in mid-period returns `scl_drive` to 1 on the next edge. Raising it again starts with a full-length low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_prescale | input | 16 | Prescaler setting PSC (divide by PSC+1) |
| cfg_low_cnt | input | 16 | Low-phase setting LOW |
| cfg_high_cnt | input | 16 | High-phase setting HIGH |
| core_run | input | 1 | 1 = core out of soft reset; 0 = settings captured |
| gen_en | input | 1 | Enable from the transfer sequencer |
| scl_drive | output | 1 | SCL level to drive (1 = released high) |
| mid_low_stb | output | 1 | One-cycle strobe at the middle of the low phase |
| rise_stb | output | 1 | One-cycle strobe on the first high cycle |

## Verification
The assertions assume that `core_run` and `gen_en` are synchronous to `clk` and free of unknown values once reset is released. They also assume that the held settings are the only timing source while the core runs. This is why the prescaler bound and the counter bounds are stated against the held copy and not against the live inputs. The stimulus changes every input only at the falling edge of the clock and loads settings with `core_run` low. In some runs it also moves the live setting inputs while the core runs, to show that the waveform keeps the captured timing.

// File: rtl/scl_rate_pkg.sv
package scl_rate_pkg;

    localparam int CFG_W = 16;
    localparam int LEN_W = CFG_W + 1;

    typedef struct packed {
        logic [CFG_W-1:0] psc;
        logic [CFG_W-1:0] low;
        logic [CFG_W-1:0] high;
    } scl_cfg_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } scl_phase_e;

    // Fixed stretch added to both phases, chosen by the prescaler setting.
    function automatic logic [2:0] phase_offset(input logic [CFG_W-1:0] psc);
        if (psc == '0)
            return 3'd7;
        else if (psc == CFG_W'(1))
            return 3'd6;
        else
            return 3'd5;
    endfunction

    function automatic logic [LEN_W-1:0] phase_len(input logic [CFG_W-1:0] cnt,
                                                   input logic [CFG_W-1:0] psc);
        return {1'b0, cnt} + LEN_W'(phase_offset(psc));
    endfunction

endpackage

// File: rtl/scl_cfg_hold.sv
module scl_cfg_hold
    import scl_rate_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     core_run,
    input  scl_cfg_t cfg_in,
    output scl_cfg_t cfg_q
);

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (!core_run)
            cfg_q <= cfg_in;
    end

    // The held copy never moves while the core keeps running.
    assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        (core_run && $past(core_run)) |-> $stable(cfg_q));

endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler
    import scl_rate_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CFG_W-1:0] div,
    output logic             tick
);

    logic [CFG_W-1:0] pcnt;

    assign tick = run && (pcnt == div);

    always_ff @(posedge clk) begin
        if (rst || !run)
            pcnt <= '0;
        else if (pcnt == div)
            pcnt <= '0;
        else
            pcnt <= pcnt + CFG_W'(1);
    end

    // The divider count never passes the setting, so each tick spacing is PSC+1.
    assert_pcnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run)) |-> (pcnt <= div));

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_rate_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     active,
    input  scl_cfg_t cfg,
    input  logic     tick,
    output logic     counting,
    output logic     scl_q,
    output logic     mid_q,
    output logic     rise_q
);

    scl_phase_e       state;
    logic [LEN_W-1:0] cnt;
    logic [LEN_W-1:0] len_low;
    logic [LEN_W-1:0] len_high;
    logic [LEN_W-1:0] half_low;
    logic             low_last;
    logic             high_last;

    assign len_low   = phase_len(cfg.low, cfg.psc);
    assign len_high  = phase_len(cfg.high, cfg.psc);
    assign half_low  = len_low >> 1;
    assign low_last  = (cnt == len_low - LEN_W'(1));
    assign high_last = (cnt == len_high - LEN_W'(1));
    assign counting  = active && (state != PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            state  <= PH_IDLE;
            cnt    <= '0;
            scl_q  <= 1'b1;
            mid_q  <= 1'b0;
            rise_q <= 1'b0;
        end else begin
            mid_q  <= 1'b0;
            rise_q <= 1'b0;
            unique case (state)
                PH_IDLE: begin
                    state <= PH_LOW;
                    cnt   <= '0;
                    scl_q <= 1'b0;
                end
                PH_LOW: begin
                    if (tick) begin
                        mid_q <= (cnt == half_low - LEN_W'(1));
                        if (low_last) begin
                            state  <= PH_HIGH;
                            cnt    <= '0;
                            scl_q  <= 1'b1;
                            rise_q <= 1'b1;
                        end else begin
                            cnt <= cnt + LEN_W'(1);
                        end
                    end
                end
                PH_HIGH: begin
                    if (tick) begin
                        if (high_last) begin
                            state <= PH_LOW;
                            cnt   <= '0;
                            scl_q <= 1'b0;
                        end else begin
                            cnt <= cnt + LEN_W'(1);
                        end
                    end
                end
                default: begin
                    state <= PH_IDLE;
                    scl_q <= 1'b1;
                end
            endcase
        end
    end

    assert_idle_high_R1: assert property (@(posedge clk) disable iff (rst)
        !$past(active) |-> (scl_q && !mid_q && !rise_q));

    assert_start_low_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(active) && $past(state) == PH_IDLE) |-> !scl_q);

    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
        (state == PH_LOW) |-> (cnt < len_low));

    assert_cnt_bound_high_R4: assert property (@(posedge clk) disable iff (rst)
        (state == PH_HIGH) |-> (cnt < len_high));

    assert_rise_edge_R6: assert property (@(posedge clk) disable iff (rst)
        rise_q |-> (scl_q && !$past(scl_q)));

    assert_mid_in_low_R7: assert property (@(posedge clk) disable iff (rst)
        mid_q |-> !scl_q);

    assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mid_q, rise_q}));

endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
    import scl_rate_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CFG_W-1:0] cfg_prescale,
    input  logic [CFG_W-1:0] cfg_low_cnt,
    input  logic [CFG_W-1:0] cfg_high_cnt,
    input  logic             core_run,
    input  logic             gen_en,
    output logic             scl_drive,
    output logic             mid_low_stb,
    output logic             rise_stb
);

    scl_cfg_t cfg_live;
    scl_cfg_t cfg_held;
    logic     active;
    logic     counting;
    logic     tick;

    assign cfg_live = '{psc: cfg_prescale, low: cfg_low_cnt, high: cfg_high_cnt};
    assign active   = core_run && gen_en;

    scl_cfg_hold u_hold (
        .clk      (clk),
        .rst      (rst),
        .core_run (core_run),
        .cfg_in   (cfg_live),
        .cfg_q    (cfg_held)
    );

    scl_prescaler u_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (counting),
        .div  (cfg_held.psc),
        .tick (tick)
    );

    scl_phase_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .active   (active),
        .cfg      (cfg_held),
        .tick     (tick),
        .counting (counting),
        .scl_q    (scl_drive),
        .mid_q    (mid_low_stb),
        .rise_q   (rise_stb)
    );

endmodule

// File: tb/tb_scl_rate_gen.sv
module tb_scl_rate_gen;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] cfg_prescale, cfg_low_cnt, cfg_high_cnt;
    logic        core_run, gen_en;
    logic        scl_drive, mid_low_stb, rise_stb;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    scl_rate_gen dut (
        .clk          (clk),
        .rst          (rst),
        .cfg_prescale (cfg_prescale),
        .cfg_low_cnt  (cfg_low_cnt),
        .cfg_high_cnt (cfg_high_cnt),
        .core_run     (core_run),
        .gen_en       (gen_en),
        .scl_drive    (scl_drive),
        .mid_low_stb  (mid_low_stb),
        .rise_stb     (rise_stb)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    function automatic int offs(input int p);   // R5 rule
        return (p == 0) ? 7 : (p == 1) ? 6 : 5;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle_outs(input string req);
        check({req, " scl"}, int'(scl_drive), 1);
        check({req, " strobes"}, int'({mid_low_stb, rise_stb}), 0);
    endtask

    // Load settings under soft reset, enable, and compare two full periods.
    task automatic run_case(input int p, input int l, input int h, input bit scramble);
        int d, lc, hc, per, half;
        int bad_scl, bad_mid, bad_rise;
        int a_scl, a_mid, a_rise;
        bit e_scl, e_mid, e_rise;
        @(negedge clk);
        core_run = 0; gen_en = 0;
        cfg_prescale = 16'(p); cfg_low_cnt = 16'(l); cfg_high_cnt = 16'(h);
        @(negedge clk);
        @(negedge clk);
        core_run = 1;
        @(negedge clk);
        gen_en = 1;
        d = offs(p);
        lc = (p + 1) * (l + d);
        hc = (p + 1) * (h + d);
        per = lc + hc;
        half = (p + 1) * ((l + d) / 2);
        bad_scl = 0; bad_mid = 0; bad_rise = 0;
        a_scl = 0; a_mid = 0; a_rise = 0;
        for (int c = 0; c < 2 * per; c++) begin
            int ph;
            @(negedge clk);
            ph = c % per;
            e_scl  = (ph >= lc);
            e_mid  = (ph == half);
            e_rise = (ph == lc);
            if (scl_drive !== e_scl && bad_scl == 0) begin bad_scl = c + 1; a_scl = scl_drive; end
            if (mid_low_stb !== e_mid && bad_mid == 0) begin bad_mid = c + 1; a_mid = mid_low_stb; end
            if (rise_stb !== e_rise && bad_rise == 0) begin bad_rise = c + 1; a_rise = rise_stb; end
            if (scramble && c == 3) begin   // R8: live inputs move while running
                cfg_prescale = 16'(p + 2);
                cfg_low_cnt  = 16'(l + 9);
                cfg_high_cnt = 16'(h + 4);
            end
        end
        if (bad_scl != 0)
            $display("FAIL R3 R4 R5 R8 p=%0d l=%0d h=%0d cycle %0d: actual scl %0d expected %0d",
                     p, l, h, bad_scl - 1, a_scl, 1 - a_scl);
        check("R3 R4 R5 scl waveform (mismatch cycle+1)", bad_scl, 0);
        if (bad_mid != 0)
            $display("FAIL R7 p=%0d l=%0d h=%0d cycle %0d: actual mid %0d expected %0d",
                     p, l, h, bad_mid - 1, a_mid, 1 - a_mid);
        check("R7 mid-low strobe (mismatch cycle+1)", bad_mid, 0);
        if (bad_rise != 0)
            $display("FAIL R6 p=%0d l=%0d h=%0d cycle %0d: actual rise %0d expected %0d",
                     p, l, h, bad_rise - 1, a_rise, 1 - a_rise);
        check("R6 rise strobe (mismatch cycle+1)", bad_rise, 0);
        @(negedge clk);
        gen_en = 0; core_run = 0;
    endtask

    initial begin
        rst = 1; core_run = 0; gen_en = 0;
        cfg_prescale = 0; cfg_low_cnt = 0; cfg_high_cnt = 0;
        repeat (3) @(negedge clk);
        idle_outs("R1 during reset");
        rst = 0;
        @(negedge clk);
        idle_outs("R1 after reset");

        // R1: only one of the two controls high keeps SCL idle.
        core_run = 1; gen_en = 0;
        repeat (4) @(negedge clk);
        idle_outs("R1 run without enable");
        core_run = 0; gen_en = 1;
        repeat (4) @(negedge clk);
        idle_outs("R1 enable under soft reset");
        gen_en = 0;

        // R2: the first edge with both controls high drops SCL.
        @(negedge clk);
        cfg_prescale = 0; cfg_low_cnt = 0; cfg_high_cnt = 0;
        @(negedge clk);
        core_run = 1;
        @(negedge clk);
        gen_en = 1;
        @(negedge clk);
        check("R2 first cycle low", int'(scl_drive), 0);
        @(negedge clk);
        gen_en = 0; core_run = 0;

        // Sweep covering all three offset values.
        for (int p = 0; p < 5; p++)
            for (int l = 0; l < 3; l++)
                for (int h = 0; h < 3; h++)
                    run_case(p, l * 3, h * 2, 1'b0);

        // R8: live inputs moved mid-run.
        run_case(0, 2, 1, 1'b1);
        run_case(3, 0, 5, 1'b1);
        run_case(1, 40, 0, 1'b1);

        // R9: abort mid-period, then restart with a full low phase.
        begin
            int lc9, low_seen;
            @(negedge clk);
            cfg_prescale = 1; cfg_low_cnt = 2; cfg_high_cnt = 1;
            @(negedge clk);
            core_run = 1;
            @(negedge clk);
            gen_en = 1;
            repeat (5) @(negedge clk);
            check("R9 low before abort", int'(scl_drive), 0);
            gen_en = 0;
            @(negedge clk);
            idle_outs("R9 abort releases scl");
            repeat (3) @(negedge clk);
            idle_outs("R9 stays idle");
            gen_en = 1;
            lc9 = 2 * (2 + 6);
            low_seen = 0;
            for (int c = 0; c < lc9 + 2; c++) begin
                @(negedge clk);
                if (scl_drive == 1'b0 && low_seen == c) low_seen++;
            end
            check("R9 full low phase after restart", low_seen, lc9);
            @(negedge clk);
            gen_en = 0; core_run = 0;
        end

        // R1: reset in mid-period.
        @(negedge clk);
        core_run = 1; gen_en = 1;
        repeat (6) @(negedge clk);
        rst = 1;
        @(negedge clk);
        idle_outs("R1 reset mid-period");
        rst = 0; core_run = 0; gen_en = 0;
        @(negedge clk);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule